// File: doc/BRIEF.md
# Single-Band Dynamic Range Compressor

This block squeezes the loudness range of one frequency band of an audio stream. Signed 16-bit samples arrive on a valid/ready input. An envelope follower tracks the sample magnitude, rising at one programmable rate and falling at another. The envelope is turned into a base-2 logarithmic level with four fractional bits, so one level unit is about 6 dB. A static curve then sets the gain. At or below the threshold only the make-up gain applies. Above it, the output level grows by 1/CR of each step in input level.

The logarithmic gain is turned back into a linear factor. This uses a 16-entry power-of-two mantissa table and an arithmetic shift. The factor scales the sample, and the result saturates to 16 bits. Each accepted sample goes through four fixed internal steps, then waits on the output until the consumer takes it. A filter bank would place one instance on each band, with settings chosen per band.

Top module: `band_compressor`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, `in_ready` is 1 and the envelope is 0.
- R2: A sample is accepted when `in_valid` and `in_ready` are both 1 at a clock edge. `in_ready` stays 0 from then until the result has been taken. `out_valid` rises exactly 4 clocks after the accepting edge. `out_data` and `out_valid` hold until an edge with `out_ready` at 1, after which `in_ready` returns to 1.
- R3: The magnitude is the absolute value of the sample, with -32768 taken as 32767.
- R4: When the magnitude exceeds the envelope, the envelope grows by (magnitude - envelope) >> `cfg_attack` (0 to 15).
- R5: Otherwise the envelope shrinks by (envelope - magnitude) >> `cfg_release` (0 to 15).
- R6: The level is 16*p + F(m), where p is the index of the highest set envelope bit. m is the 4 bits just below that bit, zero-filled when fewer exist. F(m) = round(16*log2(1 + m/16)). An envelope of 0 gives level 0.
- R7: When the level is at or below `cfg_thresh` (unsigned, 4 fractional bits), the log gain equals `cfg_makeup` (signed, 4 fractional bits).
- R8: Above the threshold, the log gain is makeup - (((level - thresh) * s) >> 8), where s = floor(256*(q-4)/q). q is `cfg_ratio`, in quarter units, clamped to the range 4 to 32.
- R9: A log gain g is applied as y = floor(x * M(g mod 16) * 2^(floor(g/16) - 8)), where M(f) = round(256 * 2^(f/16)).
- R10: Results above 32767 become 32767, and results below -32768 become -32768.
- R11: The configuration is captured when the sample is accepted. Configuration changes while that sample is in flight do not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Signed compressed sample |
| cfg_thresh | input | 8 | Threshold level, log2 units with 4 fraction bits |
| cfg_ratio | input | 6 | Compression ratio in quarter steps (4 = 1:1, 32 = 8:1) |
| cfg_attack | input | 4 | Attack shift |
| cfg_release | input | 4 | Release shift |
| cfg_makeup | input | 8 | Signed make-up gain, log2 units with 4 fraction bits |

## Verification
Two functions can act on the same sample: the attack step of the envelope and the knee of the static curve. A quiet-to-loud jump with a non-zero attack shift moves the envelope only part of the way, so whether it lands above or below the threshold decides which branch of the curve applies. The bench provokes this and also runs compression together with large make-up gain, so that the knee and output saturation meet in one result. A behavioural model in the bench carries its own envelope across all samples and judges each output bit-exactly and at its exact cycle.

// File: rtl/drc_pkg.sv
package drc_pkg;

    localparam int DW    = 16;   // sample width
    localparam int LVLW  = 8;    // log level width (4.4)
    localparam int FRACB = 4;    // fractional bits of a level
    localparam int RATW  = 6;    // ratio field, quarter steps
    localparam int SHW   = 4;    // attack / release shift width
    localparam int GW    = LVLW + 2;          // signed log gain width
    localparam int MANTW = 9;                 // linear mantissa width
    localparam int PRODW = DW + MANTW + 1;    // sample * mantissa
    localparam int SLW   = 8;                 // slope width
    localparam int RMIN  = 4;
    localparam int RMAX  = 32;
    localparam logic signed [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

    typedef logic signed [DW-1:0] sample_t;
    typedef logic        [DW-1:0] mag_t;
    typedef logic        [LVLW-1:0] level_t;
    typedef logic signed [GW-1:0] lgain_t;

    typedef struct packed {
        level_t                  thresh;
        logic [RATW-1:0]         ratio;
        logic [SHW-1:0]          attack;
        logic [SHW-1:0]          release_sh;
        logic signed [LVLW-1:0]  makeup;
    } drc_cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ENV,
        PH_LOG,
        PH_GAIN,
        PH_APPLY,
        PH_HOLD
    } phase_e;

    // round(16*log2(1+m/16))
    function automatic logic [FRACB-1:0] log_frac(input logic [FRACB-1:0] m);
        case (m)
            4'd0:  return 4'd0;
            4'd1:  return 4'd1;
            4'd2:  return 4'd3;
            4'd3:  return 4'd4;
            4'd4:  return 4'd5;
            4'd5:  return 4'd6;
            4'd6:  return 4'd7;
            4'd7:  return 4'd8;
            4'd8:  return 4'd9;
            4'd9:  return 4'd10;
            4'd10: return 4'd11;
            4'd11: return 4'd12;
            4'd12: return 4'd13;
            4'd13: return 4'd14;
            default: return 4'd15;
        endcase
    endfunction

    // round(256*2^(f/16))
    function automatic logic [MANTW-1:0] exp_mant(input logic [FRACB-1:0] f);
        case (f)
            4'd0:  return 9'd256;
            4'd1:  return 9'd267;
            4'd2:  return 9'd279;
            4'd3:  return 9'd292;
            4'd4:  return 9'd304;
            4'd5:  return 9'd318;
            4'd6:  return 9'd332;
            4'd7:  return 9'd347;
            4'd8:  return 9'd362;
            4'd9:  return 9'd378;
            4'd10: return 9'd395;
            4'd11: return 9'd412;
            4'd12: return 9'd431;
            4'd13: return 9'd450;
            4'd14: return 9'd470;
            default: return 9'd490;
        endcase
    endfunction

    function automatic sample_t sat_sample(input logic signed [PRODW-1:0] v);
        if (v > PRODW'(SMAX))
            return SMAX;
        else if (v < PRODW'(SMIN))
            return SMIN;
        else
            return DW'(v);
    endfunction

endpackage

// File: rtl/drc_envelope.sv
module drc_envelope
    import drc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  sample_t          x,
    input  logic [SHW-1:0]   attack,
    input  logic [SHW-1:0]   release_sh,
    output mag_t             env
);

    mag_t mag;
    mag_t diff;
    mag_t step;
    mag_t env_nxt;
    logic rising;

    always_comb begin
        if (x == SMIN)
            mag = mag_t'(SMAX);
        else if (x[DW-1])
            mag = mag_t'(-x);
        else
            mag = mag_t'(x);
    end

    always_comb begin
        rising = (mag > env);
        if (rising) begin
            diff    = mag - env;
            step    = diff >> attack;
            env_nxt = env + step;
        end else begin
            diff    = env - mag;
            step    = diff >> release_sh;
            env_nxt = env - step;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            env <= '0;
        else if (upd)
            env <= env_nxt;
    end

    // R4
    attack_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && mag > env) |=> (env <= $past(mag) && env >= $past(env)));

    // R5
    release_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && mag <= env) |=> (env >= $past(mag) && env <= $past(env)));

    // R3
    env_cap_chk: assert property (@(posedge clk) disable iff (rst)
        env <= mag_t'(SMAX));

endmodule

// File: rtl/drc_log2.sv
module drc_log2
    import drc_pkg::*;
(
    input  mag_t   env,
    output level_t level
);

    logic [3:0]       pos;
    logic [FRACB-1:0] mbits;

    always_comb begin
        pos = '0;
        for (int i = 0; i < DW; i++) begin
            if (env[i])
                pos = 4'(i);
        end
    end

    always_comb begin
        if (pos >= 4'(FRACB))
            mbits = FRACB'(env >> (pos - 4'(FRACB)));
        else
            mbits = FRACB'(env << (4'(FRACB) - pos));
    end

    always_comb begin
        if (env == '0)
            level = '0;
        else
            level = {pos, log_frac(mbits)};
    end

endmodule

// File: rtl/drc_curve.sv
module drc_curve
    import drc_pkg::*;
(
    input  level_t                 level,
    input  level_t                 thresh,
    input  logic [RATW-1:0]        ratio,
    input  logic signed [LVLW-1:0] makeup,
    output lgain_t                 gain
);

    logic [RATW-1:0]       q;
    logic [RATW+SLW-1:0]   num;
    logic [SLW-1:0]        slope;
    level_t                over;
    logic [LVLW+SLW-1:0]   prod;
    level_t                red;

    always_comb begin
        if (ratio < RATW'(RMIN))
            q = RATW'(RMIN);
        else if (ratio > RATW'(RMAX))
            q = RATW'(RMAX);
        else
            q = ratio;
        num   = (RATW+SLW)'(q - RATW'(RMIN)) << SLW;
        slope = SLW'(num / (RATW+SLW)'(q));
    end

    always_comb begin
        over = (level > thresh) ? (level - thresh) : '0;
        prod = (LVLW+SLW)'(over) * (LVLW+SLW)'(slope);
        red  = LVLW'(prod >> SLW);
        gain = {{(GW-LVLW){makeup[LVLW-1]}}, makeup} - lgain_t'({2'b00, red});
    end

endmodule

// File: rtl/drc_apply.sv
module drc_apply
    import drc_pkg::*;
(
    input  sample_t x,
    input  lgain_t  gain,
    output sample_t y
);

    logic signed [GW-FRACB-1:0] gi;
    logic [MANTW-1:0]           mant;
    logic signed [PRODW-1:0]    prod;
    logic signed [PRODW-1:0]    scaled;
    logic [4:0]                 sh;

    always_comb begin
        gi     = gain[GW-1:FRACB];
        mant   = exp_mant(gain[FRACB-1:0]);
        prod   = PRODW'(x) * $signed({1'b0, mant});
        sh     = 5'(6'sd8 - 6'(gi));
        scaled = prod >>> sh;
        y      = sat_sample(scaled);
    end

endmodule

// File: rtl/band_compressor.sv
module band_compressor
    import drc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [15:0] out_data,
    input  logic [7:0]  cfg_thresh,
    input  logic [5:0]  cfg_ratio,
    input  logic [3:0]  cfg_attack,
    input  logic [3:0]  cfg_release,
    input  logic [7:0]  cfg_makeup
);

    phase_e   phase;
    sample_t  x_r;
    drc_cfg_t cfg_r;
    level_t   level_r;
    lgain_t   gain_r;
    mag_t     env;
    level_t   level_c;
    lgain_t   gain_c;
    sample_t  y_c;
    logic     accept;

    assign in_ready = (phase == PH_IDLE);
    assign accept   = in_valid && in_ready;

    drc_envelope env_i (
        .clk        (clk),
        .rst        (rst),
        .upd        (phase == PH_ENV),
        .x          (x_r),
        .attack     (cfg_r.attack),
        .release_sh (cfg_r.release_sh),
        .env        (env)
    );

    drc_log2 log_i (
        .env   (env),
        .level (level_c)
    );

    drc_curve curve_i (
        .level  (level_r),
        .thresh (cfg_r.thresh),
        .ratio  (cfg_r.ratio),
        .makeup (cfg_r.makeup),
        .gain   (gain_c)
    );

    drc_apply apply_i (
        .x    (x_r),
        .gain (gain_r),
        .y    (y_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            x_r       <= '0;
            cfg_r     <= '0;
            level_r   <= '0;
            gain_r    <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        x_r              <= sample_t'(in_data);
                        cfg_r.thresh     <= cfg_thresh;
                        cfg_r.ratio      <= cfg_ratio;
                        cfg_r.attack     <= cfg_attack;
                        cfg_r.release_sh <= cfg_release;
                        cfg_r.makeup     <= cfg_makeup;
                        phase            <= PH_ENV;
                    end
                end
                PH_ENV:  phase <= PH_LOG;
                PH_LOG: begin
                    level_r <= level_c;
                    phase   <= PH_GAIN;
                end
                PH_GAIN: begin
                    gain_r <= gain_c;
                    phase  <= PH_APPLY;
                end
                PH_APPLY: begin
                    out_data  <= y_c;
                    out_valid <= 1'b1;
                    phase     <= PH_HOLD;
                end
                PH_HOLD: begin
                    if (out_ready) begin
                        out_valid <= 1'b0;
                        phase     <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> ##4 out_valid);

    // R2
    busy_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R7
    knee_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_APPLY && level_r <= cfg_r.thresh) |->
        (gain_r == {{(GW-LVLW){cfg_r.makeup[LVLW-1]}}, cfg_r.makeup}));

endmodule

// File: tb/band_compressor_tb.sv
module band_compressor_tb_top;

    localparam int CLK_P    = 10;
    localparam int WD_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_data;
    logic [7:0]  cfg_thresh = 8'd255;
    logic [5:0]  cfg_ratio = 6'd4;
    logic [3:0]  cfg_attack = 4'd0;
    logic [3:0]  cfg_release = 4'd0;
    logic [7:0]  cfg_makeup = 8'd0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int m_env  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    band_compressor dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .cfg_thresh (cfg_thresh),
        .cfg_ratio  (cfg_ratio),
        .cfg_attack (cfg_attack),
        .cfg_release(cfg_release),
        .cfg_makeup (cfg_makeup)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WD_LIMIT);
            report();
            $finish;
        end
    end

    function automatic int f_level(input int e);
        int p = 0;
        int m;
        int fr;
        if (e == 0) return 0;
        for (int i = 0; i < 16; i++)
            if (((e >> i) & 1) == 1) p = i;
        if (p >= 4) m = (e >> (p - 4)) & 15;
        else        m = (e << (4 - p)) & 15;
        fr = $rtoi(16.0 * $ln(1.0 + m / 16.0) / $ln(2.0) + 0.5);
        return p * 16 + fr;
    endfunction

    function automatic int f_gain(input int lvl, input int thr, input int q, input int mk);
        int qc = q;
        int s;
        int red = 0;
        if (qc < 4)  qc = 4;
        if (qc > 32) qc = 32;
        s = ((qc - 4) * 256) / qc;
        if (lvl > thr) red = ((lvl - thr) * s) >> 8;
        return mk - red;
    endfunction

    function automatic int f_apply(input int x, input int g);
        int gf = g & 15;
        int gi = (g - gf) / 16;
        int mant = $rtoi(256.0 * $pow(2.0, gf / 16.0) + 0.5);
        longint p = longint'(x) * mant;
        longint y = p >>> (8 - gi);
        if (y > 32767)  return 32767;
        if (y < -32768) return -32768;
        return int'(y);
    endfunction

    // offer one sample; hold = cycles out_ready kept low; scr = disturb config while busy
    task automatic send(input int x, input int hold, input bit scr, input string req);
        int mag;
        int exp;
        int got;
        logic [7:0] s_thr, s_mk;
        logic [5:0] s_rat;
        logic [3:0] s_atk, s_rel;
        mag = (x == -32768) ? 32767 : ((x < 0) ? -x : x);
        if (mag > m_env) m_env = m_env + ((mag - m_env) >> cfg_attack);
        else             m_env = m_env - ((m_env - mag) >> cfg_release);
        exp = f_apply(x, f_gain(f_level(m_env), int'(cfg_thresh), int'(cfg_ratio),
                                int'($signed(cfg_makeup))));
        check(in_ready == 1'b1, "R2 idle ready", int'(in_ready), 1);
        in_valid  = 1'b1;
        in_data   = 16'(x);
        out_ready = (hold == 0);
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        s_thr = cfg_thresh; s_mk = cfg_makeup; s_rat = cfg_ratio;
        s_atk = cfg_attack; s_rel = cfg_release;
        if (scr) begin
            // R11 disturb configuration while the sample is in flight
            cfg_thresh  = ~cfg_thresh;
            cfg_makeup  = cfg_makeup ^ 8'h5a;
            cfg_ratio   = cfg_ratio ^ 6'h17;
            cfg_attack  = ~cfg_attack;
            cfg_release = ~cfg_release;
        end
        check(!out_valid && !in_ready, "R2 busy", int'(out_valid), 0);
        repeat (3) begin
            @(posedge clk); @(negedge clk);
            check(!out_valid && !in_ready, "R2 latency", int'(out_valid), 0);
        end
        @(posedge clk); @(negedge clk);
        cfg_thresh = s_thr; cfg_makeup = s_mk; cfg_ratio = s_rat;
        cfg_attack = s_atk; cfg_release = s_rel;
        got = int'($signed(out_data));
        check(out_valid == 1'b1, "R2 valid at 4", int'(out_valid), 1);
        check(got == exp, req, got, exp);
        for (int h = 0; h < hold; h++) begin
            @(posedge clk); @(negedge clk);
            check(out_valid && int'($signed(out_data)) == exp, "R2 hold",
                  int'($signed(out_data)), exp);
        end
        out_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        check(!out_valid && in_ready, "R2 release", int'(out_valid), 0);
    endtask

    task automatic setcfg(input int thr, input int q, input int atk, input int rel, input int mk);
        cfg_thresh  = 8'(thr);
        cfg_ratio   = 6'(q);
        cfg_attack  = 4'(atk);
        cfg_release = 4'(rel);
        cfg_makeup  = 8'(mk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

        // R1 envelope starts at zero: slow attack from empty gives a small level
        setcfg(0, 32, 15, 0, 0);
        send(30000, 0, 0, "R1 env from zero");

        // unity gain, no compression
        setcfg(255, 4, 0, 0, 0);
        send(1000, 0, 0, "R9 unity");
        send(-1500, 2, 0, "R3 negative magnitude");
        send(-32768, 0, 0, "R3 most negative");

        // make-up gain, integer and fractional
        setcfg(255, 4, 0, 0, 16);
        send(1000, 0, 0, "R7 makeup x2");
        setcfg(255, 4, 0, 0, -8);
        send(1000, 1, 0, "R9 fractional cut");
        setcfg(255, 4, 0, 0, 37);
        send(-777, 0, 0, "R9 fractional boost");

        // saturation
        setcfg(255, 4, 0, 0, 127);
        send(20000, 0, 0, "R10 positive sat");
        send(-20000, 0, 0, "R10 negative sat");

        // static curve above knee
        setcfg(128, 8, 0, 0, 0);
        send(4096, 0, 0, "R8 ratio 2");
        setcfg(128, 32, 0, 0, 0);
        send(4096, 0, 0, "R8 ratio 8");
        setcfg(128, 40, 0, 0, 0);
        send(4096, 0, 0, "R8 ratio clamp high");
        setcfg(128, 2, 0, 0, 0);
        send(4096, 0, 0, "R8 ratio clamp low");
        setcfg(192, 16, 0, 0, 0);
        send(4096, 0, 0, "R7 at threshold");

        // level table over many mantissas
        setcfg(0, 32, 0, 0, 0);
        for (int k = 0; k < 16; k++)
            send(16 + k * 37 + k * k * 11, 0, 0, "R6 level");

        // attack and release rates, knee crossed during attack
        setcfg(150, 12, 3, 5, 8);
        send(100, 0, 0, "R5 release start");
        for (int k = 0; k < 6; k++) send(25000, 0, 0, "R4 attack");
        for (int k = 0; k < 6; k++) send(-50, 0, 0, "R5 release");
        setcfg(150, 12, 0, 2, 64);
        send(30000, 0, 0, "R10 sat with compression");

        // configuration captured at acceptance
        setcfg(100, 20, 1, 2, 20);
        send(12000, 1, 1, "R11 capture");
        send(-9000, 0, 1, "R11 capture");
        send(300, 0, 1, "R11 capture");

        done = 1'b1;
        report();
        $finish;
    end

endmodule